// File: doc/BRIEF.md
# Pending-Transaction Table

This block is a small, fully associative table for a last-level cache and directory controller. It holds the cache lines whose coherence transaction is still in flight. Only lines in a non-stable coherence state live here. Lines in a stable state live in the cache arrays. Each entry stores a valid flag, the line's tag and set, its transient coherence state, the current owner and a sharer mask.

Every request class has its own combinational lookup port: one for replacements, one for coherence requests and one for coherence responses. Each port compares its address against every valid entry. It returns a hit, the matching slot and that slot's contents. A port's data may be used only while its hit is high.

A single write port carries allocate, update and free commands, each aimed at a slot index. The write port uses a valid/ready handshake. A command is taken on a clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` drops only for an allocate while the table is full. The writer holds its command until it is taken or withdraws it. The block also reports the lowest free slot, which the allocation logic uses as its target. It also reports a full flag, which upstream uses to hold back request issue.

Top module: `ptt_table`

## Requirements
- R1: After reset, every slot is empty. `full` is 0, `free_index` is 0 and no lookup port hits.
- R2: An allocate (`wr_cmd` = 2'b01) taken by the handshake stores the valid flag, tag, set, state, owner and sharers in slot `wr_index`. These values are visible on the lookup ports from the following cycle.
- R3: A port hits only when a valid slot matches both its tag and its set. A match on the tag alone or on the set alone is a miss. On a hit, the port returns the slot number and that slot's state, owner and sharers.
- R4: On a miss, the port drives its index, state, owner and sharer outputs to zero.
- R5: Lookup ports work independently. Each port's result depends only on its own tag and set inputs, even when all ports look up at the same time.
- R6: An update (`wr_cmd` = 2'b10) rewrites the state, owner and sharers of slot `wr_index`. It leaves the slot's tag, set and valid flag unchanged.
- R7: A free command (`wr_cmd` = 2'b11) clears the valid flag of slot `wr_index`. From the next cycle, lookups miss on that slot and it counts as free.
- R8: `free_index` is the lowest-numbered empty slot. `full` is 1 exactly when every slot is valid, and `free_index` is 0 in that case.
- R9: While `full` is 1, an allocate is refused: `wr_ready` is 0 and the table is unchanged. Update, free and no-op (`wr_cmd` = 2'b00) commands are always ready.
- R10: A lookup in the same cycle as a write returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_tag | input | LK_PORTS x TAG_W | Tag to search, one per request class |
| lk_set | input | LK_PORTS x SET_W | Set to search, one per request class |
| lk_hit | output | LK_PORTS | Port found a valid matching slot |
| lk_index | output | LK_PORTS x IDX_W | Matching slot number (0 on miss) |
| lk_state | output | LK_PORTS x STATE_W | Transient state of the matching slot |
| lk_owner | output | LK_PORTS x OWNER_W | Owner of the matching slot |
| lk_sharers | output | LK_PORTS x SHR_W | Sharer mask of the matching slot |
| wr_valid | input | 1 | Write command present |
| wr_ready | output | 1 | Write command can be taken this cycle |
| wr_cmd | input | 2 | 00 no-op, 01 allocate, 10 update, 11 free |
| wr_index | input | IDX_W | Target slot |
| wr_tag | input | TAG_W | Tag for allocate |
| wr_set | input | SET_W | Set for allocate |
| wr_state | input | STATE_W | State for allocate or update |
| wr_owner | input | OWNER_W | Owner for allocate or update |
| wr_sharers | input | SHR_W | Sharer mask for allocate or update |
| free_index | output | IDX_W | Lowest empty slot |
| full | output | 1 | All slots valid |

## Verification
The in-line properties check, on every cycle, several relations:
- any reported hit points at a valid slot whose tag and set equal the port's inputs;
- a non-full table's free slot really is empty;
- a taken allocate leaves its slot valid;
- a free command leaves its slot empty;
- an update leaves the slot's tag alone;
- a refused allocate leaves the valid flags untouched.

Only the bench's scenarios can show the rest. These cover the lowest-first choice of free slot as the table fills and drains, and the old-data view during a write. They also cover the zeroed outputs on a miss and the separation of simultaneous lookups on different ports.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  typedef enum logic [1:0] {
    PTT_NOP    = 2'b00,
    PTT_ALLOC  = 2'b01,
    PTT_UPDATE = 2'b10,
    PTT_FREE   = 2'b11
  } ptt_cmd_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ptt_free_finder.sv
module ptt_free_finder #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = ptt_pkg::idx_bits(ENTRIES)
) (
  input  logic [ENTRIES-1:0] slot_valid,
  output logic [IDX_W-1:0]   first_free,
  output logic               all_used
);
  // Scan from the top down so the lowest empty slot is the last to win.
  always_comb begin
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_valid[i]) first_free = IDX_W'(i);
    end
    all_used = &slot_valid;
  end
endmodule

// File: rtl/ptt_match_port.sv
module ptt_match_port #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 10,
  parameter int SET_W   = 5,
  parameter int STATE_W = 3,
  parameter int OWNER_W = 4,
  parameter int SHR_W   = 8,
  localparam int IDX_W  = ptt_pkg::idx_bits(ENTRIES)
) (
  input  logic [TAG_W-1:0]                q_tag,
  input  logic [SET_W-1:0]                q_set,
  input  logic [ENTRIES-1:0]              slot_valid,
  input  logic [ENTRIES-1:0][TAG_W-1:0]   slot_tag,
  input  logic [ENTRIES-1:0][SET_W-1:0]   slot_set,
  input  logic [ENTRIES-1:0][STATE_W-1:0] slot_state,
  input  logic [ENTRIES-1:0][OWNER_W-1:0] slot_owner,
  input  logic [ENTRIES-1:0][SHR_W-1:0]   slot_shr,
  output logic                            hit,
  output logic [IDX_W-1:0]                index,
  output logic [STATE_W-1:0]              state,
  output logic [OWNER_W-1:0]              owner,
  output logic [SHR_W-1:0]                sharers
);
  logic [ENTRIES-1:0] match;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = slot_valid[i] && (slot_tag[i] == q_tag) && (slot_set[i] == q_set);
    end
  end

  always_comb begin
    hit   = 1'b0;
    index = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit   = 1'b1;
        index = IDX_W'(i);
      end
    end
  end

  // Contents are forced to zero on a miss so stale data never leaks out.
  always_comb begin
    state   = hit ? slot_state[index] : '0;
    owner   = hit ? slot_owner[index] : '0;
    sharers = hit ? slot_shr[index]   : '0;
  end
endmodule

// File: rtl/ptt_table.sv
module ptt_table #(
  parameter int ENTRIES  = 8,
  parameter int LK_PORTS = 3,
  parameter int TAG_W    = 10,
  parameter int SET_W    = 5,
  parameter int STATE_W  = 3,
  parameter int OWNER_W  = 4,
  parameter int SHR_W    = 8,
  localparam int IDX_W   = ptt_pkg::idx_bits(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [LK_PORTS-1:0][TAG_W-1:0]   lk_tag,
  input  logic [LK_PORTS-1:0][SET_W-1:0]   lk_set,
  output logic [LK_PORTS-1:0]              lk_hit,
  output logic [LK_PORTS-1:0][IDX_W-1:0]   lk_index,
  output logic [LK_PORTS-1:0][STATE_W-1:0] lk_state,
  output logic [LK_PORTS-1:0][OWNER_W-1:0] lk_owner,
  output logic [LK_PORTS-1:0][SHR_W-1:0]   lk_sharers,
  input  logic                             wr_valid,
  output logic                             wr_ready,
  input  logic [1:0]                       wr_cmd,
  input  logic [IDX_W-1:0]                 wr_index,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic [SET_W-1:0]                 wr_set,
  input  logic [STATE_W-1:0]               wr_state,
  input  logic [OWNER_W-1:0]               wr_owner,
  input  logic [SHR_W-1:0]                 wr_sharers,
  output logic [IDX_W-1:0]                 free_index,
  output logic                             full
);
  import ptt_pkg::*;

  logic [ENTRIES-1:0]              valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0]   tag_q;
  logic [ENTRIES-1:0][SET_W-1:0]   set_q;
  logic [ENTRIES-1:0][STATE_W-1:0] state_q;
  logic [ENTRIES-1:0][OWNER_W-1:0] owner_q;
  logic [ENTRIES-1:0][SHR_W-1:0]   shr_q;

  ptt_cmd_e cmd;
  logic     wr_fire;

  assign cmd      = ptt_cmd_e'(wr_cmd);
  assign wr_ready = !((cmd == PTT_ALLOC) && full);
  assign wr_fire  = wr_valid && wr_ready;

  ptt_free_finder #(.ENTRIES(ENTRIES)) i_free (
    .slot_valid (valid_q),
    .first_free (free_index),
    .all_used   (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      set_q   <= '0;
      state_q <= '0;
      owner_q <= '0;
      shr_q   <= '0;
    end else if (wr_fire) begin
      unique case (cmd)
        PTT_ALLOC: begin
          valid_q[wr_index] <= 1'b1;
          tag_q[wr_index]   <= wr_tag;
          set_q[wr_index]   <= wr_set;
          state_q[wr_index] <= wr_state;
          owner_q[wr_index] <= wr_owner;
          shr_q[wr_index]   <= wr_sharers;
        end
        PTT_UPDATE: begin
          state_q[wr_index] <= wr_state;
          owner_q[wr_index] <= wr_owner;
          shr_q[wr_index]   <= wr_sharers;
        end
        PTT_FREE: valid_q[wr_index] <= 1'b0;
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < LK_PORTS; p++) begin : g_port
    ptt_match_port #(
      .ENTRIES (ENTRIES),
      .TAG_W   (TAG_W),
      .SET_W   (SET_W),
      .STATE_W (STATE_W),
      .OWNER_W (OWNER_W),
      .SHR_W   (SHR_W)
    ) i_match (
      .q_tag      (lk_tag[p]),
      .q_set      (lk_set[p]),
      .slot_valid (valid_q),
      .slot_tag   (tag_q),
      .slot_set   (set_q),
      .slot_state (state_q),
      .slot_owner (owner_q),
      .slot_shr   (shr_q),
      .hit        (lk_hit[p]),
      .index      (lk_index[p]),
      .state      (lk_state[p]),
      .owner      (lk_owner[p]),
      .sharers    (lk_sharers[p])
    );

    // R3
    lk_hit_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit[p] |-> (valid_q[lk_index[p]] && tag_q[lk_index[p]] == lk_tag[p]
                     && set_q[lk_index[p]] == lk_set[p]));
  end

  // R8
  free_slot_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !valid_q[free_index]);

  // R2
  alloc_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && cmd == PTT_ALLOC) |=> valid_q[$past(wr_index)]);

  // R7
  free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cmd == PTT_FREE) |=> !valid_q[$past(wr_index)]);

  // R6
  update_keeps_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cmd == PTT_UPDATE) |=> (tag_q[$past(wr_index)] == $past(tag_q[wr_index])));

  // R9
  alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cmd == PTT_ALLOC && full) |=> $stable(valid_q));
endmodule

// File: tb/test_ptt_table.sv
module test_ptt_table;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8, P = 3, TW = 10, SW = 5, STW = 3, OW = 4, HW = 8, IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0][TW-1:0]  lk_tag;
  logic [P-1:0][SW-1:0]  lk_set;
  logic [P-1:0]          lk_hit;
  logic [P-1:0][IW-1:0]  lk_index;
  logic [P-1:0][STW-1:0] lk_state;
  logic [P-1:0][OW-1:0]  lk_owner;
  logic [P-1:0][HW-1:0]  lk_sharers;
  logic wr_valid, wr_ready;
  logic [1:0] wr_cmd;
  logic [IW-1:0] wr_index;
  logic [TW-1:0] wr_tag;
  logic [SW-1:0] wr_set;
  logic [STW-1:0] wr_state;
  logic [OW-1:0] wr_owner;
  logic [HW-1:0] wr_sharers;
  logic [IW-1:0] free_index;
  logic full;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptt_table i_ptt_table (
    .clk(clk), .rst_n(rst_n), .lk_tag(lk_tag), .lk_set(lk_set), .lk_hit(lk_hit),
    .lk_index(lk_index), .lk_state(lk_state), .lk_owner(lk_owner),
    .lk_sharers(lk_sharers), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_cmd(wr_cmd), .wr_index(wr_index), .wr_tag(wr_tag), .wr_set(wr_set),
    .wr_state(wr_state), .wr_owner(wr_owner), .wr_sharers(wr_sharers),
    .free_index(free_index), .full(full)
  );

  typedef struct {
    int port; bit hit; int idx; int st; int ow; int sh; int req;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Monitor: pops every expected lookup and compares it with the port outputs.
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (lk_hit[e.port] !== e.hit || int'(lk_index[e.port]) != e.idx ||
          int'(lk_state[e.port]) != e.st || int'(lk_owner[e.port]) != e.ow ||
          int'(lk_sharers[e.port]) != e.sh) begin
        n_fail++;
        $display("FAIL R%0d port %0d: hit=%0b idx=%0d st=%0d ow=%0d sh=%0h expected hit=%0b idx=%0d st=%0d ow=%0d sh=%0h",
          e.req, e.port, lk_hit[e.port], lk_index[e.port], lk_state[e.port],
          lk_owner[e.port], lk_sharers[e.port], e.hit, e.idx, e.st, e.ow, e.sh);
      end
    end
  end

  task automatic look(int p, int tag, int set, bit hit, int idx, int st, int ow, int sh, int req);
    exp_t e;
    lk_tag[p] = TW'(tag);
    lk_set[p] = SW'(set);
    e.port = p; e.hit = hit; e.idx = idx; e.st = st; e.ow = ow; e.sh = sh; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic sample();
    #2; ->chk_ev; #1;
  endtask

  task automatic check_status(bit f, int fi, int req);
    n_chk++;
    if (full !== f || int'(free_index) != fi) begin
      n_fail++;
      $display("FAIL R%0d status: full=%0b free=%0d expected full=%0b free=%0d",
        req, full, free_index, f, fi);
    end
  endtask

  task automatic check_ready(bit r, int req);
    n_chk++;
    if (wr_ready !== r) begin
      n_fail++;
      $display("FAIL R%0d wr_ready=%0b expected %0b", req, wr_ready, r);
    end
  endtask

  task automatic wr_put(int cmd, int idx, int tag, int set, int st, int ow, int sh);
    wr_valid = 1'b1; wr_cmd = 2'(cmd); wr_index = IW'(idx); wr_tag = TW'(tag);
    wr_set = SW'(set); wr_state = STW'(st); wr_owner = OW'(ow); wr_sharers = HW'(sh);
  endtask

  task automatic step_clear();
    @(negedge clk);
    wr_valid = 1'b0; wr_cmd = 2'b00;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: finished=0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    lk_tag = '0; lk_set = '0;
    wr_valid = 1'b0; wr_cmd = 2'b00; wr_index = '0; wr_tag = '0; wr_set = '0;
    wr_state = '0; wr_owner = '0; wr_sharers = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R4: empty table, every port misses with zeroed data
    look(0, 0, 0, 0, 0, 0, 0, 0, 1);
    look(1, 5, 2, 0, 0, 0, 0, 0, 4);
    look(2, 'h3FF, 31, 0, 0, 0, 0, 0, 1);
    sample();
    check_status(0, 0, 1);

    // R2 / R10: allocate slot 0; same-cycle lookup still misses
    @(negedge clk);
    wr_put(1, 0, 'h12, 3, 5, 2, 'h05);
    look(0, 'h12, 3, 0, 0, 0, 0, 0, 10);
    sample();
    check_ready(1, 2);
    step_clear();
    look(0, 'h12, 3, 1, 0, 5, 2, 'h05, 2);
    sample();
    check_status(0, 1, 8);

    // R3 / R5: same tag other set in slot 1; ports searched together
    wr_put(1, 1, 'h12, 4, 2, 7, 'h80);
    step_clear();
    look(0, 'h12, 3, 1, 0, 5, 2, 'h05, 5);
    look(1, 'h12, 4, 1, 1, 2, 7, 'h80, 3);
    look(2, 'h13, 3, 0, 0, 0, 0, 0, 3);
    sample();
    check_status(0, 2, 8);

    // R6: update slot 0 with junk address fields; tag/set keep old values
    wr_put(2, 0, 'h3FF, 31, 6, 3, 'hF0);
    check_ready(1, 6);
    step_clear();
    look(0, 'h12, 3, 1, 0, 6, 3, 'hF0, 6);
    look(1, 'h3FF, 31, 0, 0, 0, 0, 0, 6);
    look(2, 'h12, 4, 1, 1, 2, 7, 'h80, 5);
    sample();

    // R7: free slot 0
    wr_put(3, 0, 0, 0, 0, 0, 0);
    step_clear();
    look(0, 'h12, 3, 0, 0, 0, 0, 0, 7);
    sample();
    check_status(0, 0, 8);

    // R8: fill remaining slots, lowest free slot first
    for (int k = 0; k < 7; k++) begin
      int idx;
      idx = (k == 0) ? 0 : k + 1;
      check_status(0, idx, 8);
      wr_put(1, idx, 'h100 + idx, idx, 1, idx, 1 << idx);
      step_clear();
    end
    check_status(1, 0, 8);

    // R9: allocate refused while full, table unchanged
    wr_put(1, 0, 'h2AA, 9, 4, 4, 4);
    check_ready(0, 9);
    step_clear();
    look(0, 'h2AA, 9, 0, 0, 0, 0, 0, 9);
    look(1, 'h100, 0, 1, 0, 1, 0, 'h01, 9);
    sample();
    check_status(1, 0, 9);

    // R9 / R6: update still accepted while full
    wr_put(2, 7, 0, 0, 3, 1, 'h11);
    check_ready(1, 9);
    step_clear();
    look(2, 'h107, 7, 1, 7, 3, 1, 'h11, 6);
    sample();

    // R7 / R8: drain slots 5 then 2; lowest empty wins
    wr_put(3, 5, 0, 0, 0, 0, 0);
    step_clear();
    check_status(0, 5, 7);
    wr_put(3, 2, 0, 0, 0, 0, 0);
    step_clear();
    check_status(0, 2, 8);
    look(0, 'h105, 5, 0, 0, 0, 0, 0, 7);
    look(1, 'h102, 2, 0, 0, 0, 0, 0, 7);
    look(2, 'h103, 3, 1, 3, 1, 3, 'h08, 5);
    sample();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule